// File: doc/BRIEF.md
# Partitioned Subword Adder

This block is a 64-bit adder whose internal carry ripple can be broken at byte and half-word boundaries. A two-bit mode input picks the split. The same hardware then produces one 64-bit sum, four independent 16-bit sums, or eight independent 8-bit sums, all from a single pair of packed operands. Every lane wraps modulo two to the power of its width. There is no saturation.

Operands and mode are captured on a clock edge. The packed sum and a per-lane carry vector appear on registered outputs after that same edge. Lane j of the carry vector is bit j, and it holds the carry out of the most significant bit of lane j. Entries above the active lane count read 0.

Top module: `simd_partition_add`

## Requirements
- R1: A rising clock edge with `rst_n` low clears `sum_q` and `lane_cout_q` to zero.
- R2: The outputs change only on a rising edge, and show the result of the operands and mode present at that edge. They hold steady while inputs change between edges.
- R3: With `lane_mode` = 2'b00, `sum_q` is (a + b) mod 2^64, `lane_cout_q[0]` is the carry out of bit 63, and `lane_cout_q[7:1]` is zero.
- R4: With `lane_mode` = 2'b01, each 16-bit lane j (bits 16j+15 down to 16j, j = 0..3) of `sum_q` is the lane-j sum mod 2^16.
- R5: With `lane_mode` = 2'b10, each byte lane j (bits 8j+7 down to 8j, j = 0..7) of `sum_q` is the byte sum mod 2^8.
- R6: `lane_mode` = 2'b11 gives exactly the results of 2'b00.
- R7: `lane_cout_q[j]` is the carry out of lane j in the active mode. In the 4x16 mode, bits 7..4 read zero.
- R8: A carry out of one lane never enters the next lane. For example, all-ones plus one yields zero in every lane, with every active lane's carry set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 64 | Packed first operand |
| op_b | input | 64 | Packed second operand |
| lane_mode | input | 2 | 00: 1x64, 01: 4x16, 10: 8x8, 11: 1x64 |
| sum_q | output | 64 | Registered packed lane sums |
| lane_cout_q | output | 8 | Registered per-lane carry outs, lane j at bit j |

## Verification
The hardest case to reach from the ports is a carry that arrives exactly at a cut boundary. In that case a missing or misplaced cut would corrupt only the neighbouring lane. The sweep therefore gives each byte lane a different value derived from the loop indices. This produces lane overflows at every boundary in all four mode codes. All-ones plus one, and the same pattern with only the top bit of one lane set, are then applied in each mode. These force a carry at every boundary at once.

// File: rtl/simd_add_pkg.sv
// Package: shared mode type for the partitioned subword adder.
// Assumes: two-bit mode codes; the spare code is treated as full width.
package simd_add_pkg;
    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_HALF  = 2'b01,
        MODE_BYTE  = 2'b10,
        MODE_SPARE = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/simd_cut_ctrl.sv
// Module: simd_cut_ctrl
// Decides, per slice, whether the incoming carry is forced to zero.
// Assumes: slice 0 never takes a carry in; MID_SLICES slices form one
// mid-size lane; the spare mode code behaves as full width.
module simd_cut_ctrl
    import simd_add_pkg::*;
#(
    parameter int N_SLICES   = 8,
    parameter int MID_SLICES = 2
) (
    input  lane_mode_e          mode,
    output logic [N_SLICES-1:0] cut
);
    // Per-slice cut decision from the selected lane split.
    always_comb begin
        for (int i = 0; i < N_SLICES; i++) begin
            unique case (mode)
                MODE_BYTE: cut[i] = 1'b1;
                MODE_HALF: cut[i] = ((i % MID_SLICES) == 0);
                default:   cut[i] = (i == 0);
            endcase
        end
    end
endmodule

// File: rtl/simd_slice_add.sv
// Module: simd_slice_add
// One narrow ripple slice: sum of two operands plus a carry in.
// Assumes: SLICE_W >= 1; caller decides whether the carry in is cut.
module simd_slice_add #(
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    output logic [SLICE_W-1:0] sum,
    output logic               cout
);
    localparam int EXT_W = SLICE_W + 1;
    // Plain extended-width add for this slice.
    always_comb begin
        logic [EXT_W-1:0] ext;
        ext  = EXT_W'(a) + EXT_W'(b) + EXT_W'(cin);
        sum  = ext[SLICE_W-1:0];
        cout = ext[SLICE_W];
    end
endmodule

// File: rtl/simd_cout_pack.sv
// Module: simd_cout_pack
// Gathers slice carry outs into a lane-indexed carry vector.
// Assumes: lane j of the active mode lands at bit j; unused bits are zero.
module simd_cout_pack
    import simd_add_pkg::*;
#(
    parameter int N_SLICES   = 8,
    parameter int MID_SLICES = 2
) (
    input  lane_mode_e          mode,
    input  logic [N_SLICES-1:0] slice_cout,
    output logic [N_SLICES-1:0] lane_cout
);
    localparam int N_MID = N_SLICES / MID_SLICES;
    // Select the carry of each lane's top slice for the active split.
    always_comb begin
        lane_cout = '0;
        unique case (mode)
            MODE_BYTE: lane_cout = slice_cout;
            MODE_HALF: begin
                for (int j = 0; j < N_MID; j++)
                    lane_cout[j] = slice_cout[j*MID_SLICES + MID_SLICES - 1];
            end
            default:   lane_cout[0] = slice_cout[N_SLICES-1];
        endcase
    end
endmodule

// File: rtl/simd_partition_add.sv
// Module: simd_partition_add (top)
// Registered packed adder: one full-width, N_MID mid-width or N_SLICES
// slice-width wrap-around sums from one ripple chain with gated carries.
// Assumes: synchronous active-low reset; one cycle from inputs to outputs.
module simd_partition_add
    import simd_add_pkg::*;
#(
    parameter int SLICE_W    = 8,
    parameter int N_SLICES   = 8,
    parameter int MID_SLICES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLICE_W*N_SLICES-1:0]   op_a,
    input  logic [SLICE_W*N_SLICES-1:0]   op_b,
    input  logic [1:0]                    lane_mode,
    output logic [SLICE_W*N_SLICES-1:0]   sum_q,
    output logic [N_SLICES-1:0]           lane_cout_q
);
    localparam int DATA_W = SLICE_W * N_SLICES;
    localparam int MID_W  = SLICE_W * MID_SLICES;
    localparam int N_MID  = N_SLICES / MID_SLICES;

    lane_mode_e          mode;
    logic [N_SLICES-1:0] cut;
    logic [N_SLICES-1:0] cin;
    logic [N_SLICES-1:0] slice_cout;
    logic [N_SLICES-1:0] lane_cout;
    logic [DATA_W-1:0]   sum_d;

    assign mode = lane_mode_e'(lane_mode);

    simd_cut_ctrl #(.N_SLICES(N_SLICES), .MID_SLICES(MID_SLICES)) i_cut (
        .mode (mode),
        .cut  (cut)
    );

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        // Carry into slice i: zero where the chain is cut.
        if (i == 0) begin : g_first
            assign cin[i] = 1'b0;
        end else begin : g_rest
            assign cin[i] = cut[i] ? 1'b0 : slice_cout[i-1];
        end
        simd_slice_add #(.SLICE_W(SLICE_W)) i_slice (
            .a    (op_a[i*SLICE_W +: SLICE_W]),
            .b    (op_b[i*SLICE_W +: SLICE_W]),
            .cin  (cin[i]),
            .sum  (sum_d[i*SLICE_W +: SLICE_W]),
            .cout (slice_cout[i])
        );
    end

    simd_cout_pack #(.N_SLICES(N_SLICES), .MID_SLICES(MID_SLICES)) i_pack (
        .mode       (mode),
        .slice_cout (slice_cout),
        .lane_cout  (lane_cout)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q       <= '0;
            lane_cout_q <= '0;
        end else begin
            sum_q       <= sum_d;
            lane_cout_q <= lane_cout;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0 && lane_cout_q == '0));

    // R3 R6
    full_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(lane_mode) == 2'b00 || $past(lane_mode) == 2'b11))
        |-> ({lane_cout_q[0], sum_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})
             && lane_cout_q[N_SLICES-1:1] == '0));

    // R7
    mid_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lane_mode) == 2'b01)
        |-> (lane_cout_q[N_SLICES-1:N_MID] == '0));

    for (genvar j = 0; j < N_MID; j++) begin : g_mid_chk
        // R4
        mid_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(lane_mode) == 2'b01)
            |-> ({lane_cout_q[j], sum_q[j*MID_W +: MID_W]} ==
                 ({1'b0, $past(op_a[j*MID_W +: MID_W])} +
                  {1'b0, $past(op_b[j*MID_W +: MID_W])})));
    end

    for (genvar j = 0; j < N_SLICES; j++) begin : g_byte_chk
        // R5 R8
        byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(lane_mode) == 2'b10)
            |-> ({lane_cout_q[j], sum_q[j*SLICE_W +: SLICE_W]} ==
                 ({1'b0, $past(op_a[j*SLICE_W +: SLICE_W])} +
                  {1'b0, $past(op_b[j*SLICE_W +: SLICE_W])})));
    end
endmodule

// File: tb/test_simd_partition_add.sv
module test_simd_partition_add;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  lane_mode = 2'b00;
    logic [63:0] sum_q;
    logic [7:0]  lane_cout_q;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_partition_add i_simd_partition_add (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_a        (op_a),
        .op_b        (op_b),
        .lane_mode   (lane_mode),
        .sum_q       (sum_q),
        .lane_cout_q (lane_cout_q)
    );

    // Lane-by-lane reference computed from the requirement widths.
    function automatic void ref_add(input logic [63:0] a, input logic [63:0] b,
                                    input logic [1:0] m,
                                    output logic [63:0] s, output logic [7:0] cv);
        int w;
        logic [63:0] mask;
        logic [64:0] t;
        w = (m == 2'b01) ? 16 : (m == 2'b10) ? 8 : 64;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        s = '0;
        cv = '0;
        for (int j = 0; j < 64 / w; j++) begin
            t = {1'b0, (a >> (j*w)) & mask} + {1'b0, (b >> (j*w)) & mask};
            s = s | ((t[63:0] & mask) << (j*w));
            cv[j] = t[w];
        end
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R3/R7";
            2'b01:   return "R4/R7";
            2'b10:   return "R5/R7";
            default: return "R6/R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at falling edge, register at rising edge, sample just after.
    task automatic apply(input logic [63:0] a, input logic [63:0] b,
                         input logic [1:0] m, input string req);
        logic [63:0] es;
        logic [7:0]  ec;
        @(negedge clk);
        op_a = a; op_b = b; lane_mode = m;
        @(posedge clk);
        #1;
        ref_add(a, b, m, es, ec);
        check(req, {lane_cout_q, sum_q}, {ec, es});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [63:0] a, b, held;
        logic [7:0]  heldc;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", {lane_cout_q, sum_q}, 72'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: all-ones plus one in every mode, and top-bit-per-lane pattern
        for (int m = 0; m < 4; m++) begin
            apply('1, 64'h0101_0101_0101_0101, 2'(m), "R8");
            apply('1, 64'h0001_0001_0001_0001, 2'(m), "R8");
            apply(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'(m), "R8");
            apply(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'(m), "R8");
        end

        // R3 R4 R5 R6 R7: sweep of per-byte values in every mode
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 256; i++) begin
                for (int j = 0; j < 256; j += 7) begin
                    for (int k = 0; k < 8; k++) begin
                        a[k*8 +: 8] = 8'(i) ^ 8'(k * 37);
                        b[k*8 +: 8] = 8'(j) + 8'(k * 53);
                    end
                    apply(a, b, 2'(m), req_of(2'(m)));
                end
            end
        end

        // R2: outputs hold between edges while inputs change
        apply(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 2'b10, "R5");
        held = sum_q;
        heldc = lane_cout_q;
        @(negedge clk);
        op_a = '1; op_b = '1; lane_mode = 2'b00;
        #1;
        check("R2", {lane_cout_q, sum_q}, {heldc, held});

        // R1: reset mid-run clears outputs
        apply('1, '1, 2'b00, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {lane_cout_q, sum_q}, 72'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule